// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block joins a byte-wide transmitter and an oversampling receiver that share one mode register and one bit-rate generator. The transmitter accepts a byte over a valid/ready handshake and sends it on an idle-high line. Each frame is a low start bit, eight data bits with the least significant first, an optional extra bit, and one or two high stop bits. The receiver watches its own line. It finds a start bit, confirms it at mid-bit, samples each later bit at the middle of its period, and presents the rebuilt byte for one cycle. A framing error flag and a parity error flag travel with the byte.

The extra bit has two meanings. If multiprocessor format is selected, the extra bit is an address/data marker: the transmitter takes it from an input pin and the receiver reports it. In that case any parity setting is ignored. If multiprocessor format is off and parity is enabled, the extra bit is an even or odd parity bit. The bit rate comes from a clock prescaler (divide by 1, 4, 16 or 64) followed by a reloading 8-bit divisor counter. That counter produces sixteen ticks per bit.

Top module: `async_serial_core`

## Requirements
- R1: Out of reset `txLine` is high, `txReady` is high and `rxValid` is low. The line stays high while the transmitter is idle.
- R2: A pulse on `modeWr` loads `modeIn` into the mode register. The fields are: bits [1:0] clock select, bit 2 two-stop select, bit 3 parity enable, bit 4 odd parity, bit 5 multiprocessor select. After reset every field is 0, which gives one stop bit, no extra bit and an undivided clock.
- R3: Clock select codes 0, 1, 2 and 3 divide the system clock by 1, 4, 16 and 64. One bit lasts 16 × (`rateDivisor` + 1) × prescale system clocks.
- R4: A byte is accepted on a cycle where `txValid` and `txReady` are both high. The frame then goes out in this order: a low start bit, the data bits LSB first, the extra bit if configured, and the stop bits. `txReady` stays low until the last configured stop bit has been sent in full.
- R5: With the two-stop select at 0 the transmitter sends one high stop bit. With it at 1 the transmitter sends two.
- R6: With parity enabled and multiprocessor format off, the extra bit is chosen so that the data plus extra bit hold an even number of ones (odd-parity field 0) or an odd number of ones (odd-parity field 1).
- R7: With multiprocessor format selected, the extra bit is sent from `txMpBit` and received into `rxMpBit`, and the parity fields have no effect on either side. When the format is off, `rxMpBit` reads 0.
- R8: The receiver checks a start bit at mid-bit. If the line is high again by then, the receiver goes back to idle and no character is produced.
- R9: The receiver checks only the first stop bit, whatever the two-stop select says. If that bit is low, the character is still delivered, with `rxFrameErr` set. A low level right after a good first stop bit is taken as the start bit of the next character.
- R10: `rxParityErr` is set only when parity is enabled, multiprocessor format is off, and the received extra bit does not match the parity of the received data.
- R11: `rxValid` is a single-cycle pulse. `rxData` and the flags keep their values until the next character arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Load strobe for the mode register |
| modeIn | input | 6 | Mode value (fields as in R2) |
| rateDivisor | input | DIV_W | Reload value of the bit-rate counter |
| txData | input | DATA_W | Byte to transmit |
| txValid | input | 1 | Transmit byte is valid |
| txMpBit | input | 1 | Extra bit sent in multiprocessor format |
| txReady | output | 1 | Transmitter can accept a byte |
| txLine | output | 1 | Serial output, idle high |
| rxLine | input | 1 | Serial input, idle high |
| rxData | output | DATA_W | Last received byte |
| rxValid | output | 1 | One-cycle pulse for a new character |
| rxMpBit | output | 1 | Received multiprocessor marker bit |
| rxFrameErr | output | 1 | First stop bit was sampled low |
| rxParityErr | output | 1 | Extra bit did not match the parity |

## Verification
The bench goes after the stop-bit corner from both sides. On the transmit side it sends back-to-back bytes and measures the high gap before the next start bit; a transmitter that dropped or added a stop bit shows a gap one bit too short or too long. On the receive side it drives a second stop bit that is low and is really the next start bit; a receiver that checked both stops would flag a framing error or lose the second byte. It also sends a start glitch shorter than half a bit, and a short low stop bit that must not turn into a false character; a receiver without mid-bit start checking would produce bytes that were never sent. It covers all four prescale codes and a byte whose parity would contradict the marker bit in multiprocessor format; logic that let parity override that format would send the wrong extra bit or report a parity error that should not exist.

// File: rtl/asc_pkg.sv
package asc_pkg;

  // Mode register layout: [5] mpSel, [4] parityOdd, [3] parityEn,
  // [2] twoStop, [1:0] clkSel.
  typedef struct packed {
    logic       mpSel;
    logic       parityOdd;
    logic       parityEn;
    logic       twoStop;
    logic [1:0] clkSel;
  } asc_mode_t;

  // Source of the next transmit line level.
  typedef enum logic [1:0] {
    SRC_MARK,
    SRC_SPACE,
    SRC_DATA,
    SRC_EXTRA
  } asc_src_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     txLoad;
    logic     txShift;
    asc_src_e txSrc;
    logic     rxShift;
    logic     rxTakeExtra;
    logic     rxFinish;
  } asc_strobe_t;

endpackage

// File: rtl/asc_baud.sv
module asc_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       clkSel,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  localparam int PRE_W = 6;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             preTick;
  logic [DIV_W-1:0] divCnt;

  // Free-running prescaler; a masked all-ones pattern marks each period.
  always_comb begin
    case (clkSel)
      2'd0:    preMask = PRE_W'(0);
      2'd1:    preMask = PRE_W'(3);
      2'd2:    preMask = PRE_W'(15);
      default: preMask = PRE_W'(63);
    endcase
  end

  assign preTick = (preCnt & preMask) == preMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
      tick   <= 1'b0;
    end else begin
      preCnt <= preCnt + 1'b1;
      tick   <= 1'b0;
      if (preTick) begin
        if (divCnt == '0) begin
          divCnt <= divisor;
          tick   <= 1'b1;
        end else begin
          divCnt <= divCnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/asc_ctrl.sv
module asc_ctrl
  import asc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hasExtra,
  input  logic        twoStop,
  input  logic        tick,
  input  logic        txValid,
  input  logic        rxBit,
  output logic        txReady,
  output asc_strobe_t strobe
);

  localparam int TW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(OVS - 1);
  localparam logic [TW-1:0] HALF_TICK = TW'(OVS / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

  typedef enum logic [2:0] {
    T_IDLE, T_START, T_DATA, T_EXTRA, T_STOP1, T_STOP2
  } tx_state_e;

  typedef enum logic [2:0] {
    R_IDLE, R_START, R_DATA, R_EXTRA, R_STOP
  } rx_state_e;

  tx_state_e     tState;
  rx_state_e     rState;
  logic [TW-1:0] tTick;
  logic [TW-1:0] rTick;
  logic [BW-1:0] tBit;
  logic [BW-1:0] rBit;
  logic          txEnd;
  logic          rxEnd;
  logic          rxHalf;

  assign txEnd  = tick && (tTick == LAST_TICK);
  assign rxEnd  = tick && (rTick == LAST_TICK);
  assign rxHalf = tick && (rTick == HALF_TICK);

  // Transmit sequencer: one bit lasts OVS ticks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tState <= T_IDLE;
      tTick  <= '0;
      tBit   <= '0;
    end else if (tState == T_IDLE) begin
      tTick <= '0;
      if (txValid) tState <= T_START;
    end else if (tick) begin
      tTick <= txEnd ? '0 : tTick + 1'b1;
      if (txEnd) begin
        case (tState)
          T_START: begin
            tState <= T_DATA;
            tBit   <= '0;
          end
          T_DATA: begin
            tBit <= tBit + 1'b1;
            if (tBit == LAST_BIT) tState <= hasExtra ? T_EXTRA : T_STOP1;
          end
          T_EXTRA: tState <= T_STOP1;
          T_STOP1: tState <= twoStop ? T_STOP2 : T_IDLE;
          default: tState <= T_IDLE;
        endcase
      end
    end
  end

  // Receive sequencer: start is confirmed at half a bit, then one
  // sample every OVS ticks; it rests after the first stop sample.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rState <= R_IDLE;
      rTick  <= '0;
      rBit   <= '0;
    end else begin
      case (rState)
        R_IDLE: begin
          rTick <= '0;
          if (!rxBit) rState <= R_START;
        end
        R_START: begin
          if (rxHalf) begin
            rTick <= '0;
            rBit  <= '0;
            rState <= rxBit ? R_IDLE : R_DATA;
          end else if (tick) begin
            rTick <= rTick + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            rTick <= rxEnd ? '0 : rTick + 1'b1;
            if (rxEnd) begin
              case (rState)
                R_DATA: begin
                  rBit <= rBit + 1'b1;
                  if (rBit == LAST_BIT) rState <= hasExtra ? R_EXTRA : R_STOP;
                end
                R_EXTRA: rState <= R_STOP;
                default: rState <= R_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign txReady = (tState == T_IDLE);

  always_comb begin
    strobe             = '0;
    strobe.txLoad      = txReady && txValid;
    strobe.txShift     = (tState == T_DATA) && txEnd;
    strobe.rxShift     = (rState == R_DATA) && rxEnd;
    strobe.rxTakeExtra = (rState == R_EXTRA) && rxEnd;
    strobe.rxFinish    = (rState == R_STOP) && rxEnd;
    case (tState)
      T_START: strobe.txSrc = SRC_SPACE;
      T_DATA:  strobe.txSrc = SRC_DATA;
      T_EXTRA: strobe.txSrc = SRC_EXTRA;
      default: strobe.txSrc = SRC_MARK;
    endcase
  end

endmodule

// File: rtl/asc_dpath.sv
module asc_dpath
  import asc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  asc_strobe_t       strobe,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              mpSel,
  input  logic [DATA_W-1:0] txData,
  input  logic              txMpBit,
  output logic              txLine,
  input  logic              rxLine,
  output logic              rxBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxMpBit,
  output logic              rxFrameErr,
  output logic              rxParityErr
);

  logic [DATA_W-1:0] txShiftQ;
  logic              txExtraQ;
  logic [1:0]        rxSync;
  logic [DATA_W-1:0] rxShiftQ;
  logic              rxExtraQ;
  logic              rxParityCalc;

  assign rxBit        = rxSync[1];
  assign rxParityCalc = (^rxShiftQ) ^ parityOdd;

  // Transmit shift register and registered line driver.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShiftQ <= '0;
      txExtraQ <= 1'b0;
      txLine   <= 1'b1;
    end else begin
      if (strobe.txLoad) begin
        txShiftQ <= txData;
        txExtraQ <= mpSel ? txMpBit : ((^txData) ^ parityOdd);
      end else if (strobe.txShift) begin
        txShiftQ <= txShiftQ >> 1;
      end
      case (strobe.txSrc)
        SRC_MARK:  txLine <= 1'b1;
        SRC_SPACE: txLine <= 1'b0;
        SRC_DATA:  txLine <= txShiftQ[0];
        SRC_EXTRA: txLine <= txExtraQ;
        default:   txLine <= 1'b1;
      endcase
    end
  end

  // Receive synchronizer, shift register and result registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync      <= 2'b11;
      rxShiftQ    <= '0;
      rxExtraQ    <= 1'b0;
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxMpBit     <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxParityErr <= 1'b0;
    end else begin
      rxSync  <= {rxSync[0], rxLine};
      rxValid <= strobe.rxFinish;
      if (strobe.rxShift) rxShiftQ <= {rxBit, rxShiftQ[DATA_W-1:1]};
      if (strobe.rxTakeExtra) rxExtraQ <= rxBit;
      if (strobe.rxFinish) begin
        rxData      <= rxShiftQ;
        rxFrameErr  <= !rxBit;
        rxMpBit     <= mpSel && rxExtraQ;
        rxParityErr <= parityEn && !mpSel && (rxExtraQ != rxParityCalc);
      end
    end
  end

endmodule

// File: rtl/async_serial_core.sv
module async_serial_core
  import asc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [5:0]        modeIn,
  input  logic [DIV_W-1:0]  rateDivisor,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              txMpBit,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxMpBit,
  output logic              rxFrameErr,
  output logic              rxParityErr
);

  asc_mode_t   modeQ;
  asc_strobe_t strobe;
  logic        tick;
  logic        rxBit;

  always_ff @(posedge clk) begin
    if (!rstN)       modeQ <= '0;
    else if (modeWr) modeQ <= asc_mode_t'(modeIn);
  end

  asc_baud #(.DIV_W(DIV_W)) uBaud (
    .clk     (clk),
    .rstN    (rstN),
    .clkSel  (modeQ.clkSel),
    .divisor (rateDivisor),
    .tick    (tick)
  );

  asc_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hasExtra (modeQ.parityEn | modeQ.mpSel),
    .twoStop  (modeQ.twoStop),
    .tick     (tick),
    .txValid  (txValid),
    .rxBit    (rxBit),
    .txReady  (txReady),
    .strobe   (strobe)
  );

  asc_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .parityEn    (modeQ.parityEn),
    .parityOdd   (modeQ.parityOdd),
    .mpSel       (modeQ.mpSel),
    .txData      (txData),
    .txMpBit     (txMpBit),
    .txLine      (txLine),
    .rxLine      (rxLine),
    .rxBit       (rxBit),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .rxMpBit     (rxMpBit),
    .rxFrameErr  (rxFrameErr),
    .rxParityErr (rxParityErr)
  );

endmodule

// File: rtl/asc_checker.sv
module asc_checker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic txLine,
  input logic rxValid,
  input logic rxMpBit,
  input logic rxParityErr,
  input logic mpSel,
  input logic parityEn
);

  // R1: an idle transmitter holds the line at mark level
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R4: acceptance drops ready at once
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R4: the start bit appears on the line right after acceptance
  a_r4_start_follows: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> ##1 !txLine);

  // R11: the character strobe lasts one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R10: no parity error unless parity is on and the marker format is off
  a_r10_parity_gated: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && ($past(mpSel) || !$past(parityEn))) |-> !rxParityErr);

  // R7: the marker output stays 0 outside the marker format
  a_r7_marker_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !$past(mpSel)) |-> !rxMpBit);

endmodule

bind async_serial_core asc_checker chk (
  .clk         (clk),
  .rstN        (rstN),
  .txValid     (txValid),
  .txReady     (txReady),
  .txLine      (txLine),
  .rxValid     (rxValid),
  .rxMpBit     (rxMpBit),
  .rxParityErr (rxParityErr),
  .mpSel       (modeQ.mpSel),
  .parityEn    (modeQ.parityEn)
);

// File: tb/async_serial_core_test.sv
module async_serial_core_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWr = 1'b0;
  logic [5:0] modeIn = '0;
  logic [7:0] rateDivisor = '0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txMpBit = 1'b0;
  logic       txReady;
  logic       txLine;
  logic       rxLine;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxMpBit;
  logic       rxFrameErr;
  logic       rxParityErr;

  logic loopSel = 1'b1;
  logic benchLine = 1'b1;
  assign rxLine = loopSel ? txLine : benchLine;

  always #4 clk = ~clk;

  async_serial_core uut (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeIn(modeIn),
    .rateDivisor(rateDivisor), .txData(txData), .txValid(txValid),
    .txMpBit(txMpBit), .txReady(txReady), .txLine(txLine), .rxLine(rxLine),
    .rxData(rxData), .rxValid(rxValid), .rxMpBit(rxMpBit),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr)
  );

  typedef struct {
    logic [7:0] d;
    logic       hasX;
    logic       x;
    int         stops;
    string      req;
  } tx_item_t;

  typedef struct {
    logic [10:0] v;
    string       req;
  } rx_item_t;

  tx_item_t txExp[$];
  rx_item_t rxExp[$];

  int  checks = 0;
  int  fails = 0;
  int  bitClks = 16;
  int  rxCount = 0;
  bit  curMp = 1'b0;
  bit  txBusy = 1'b0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit par(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic setMode(input bit twoStop, input bit pEn, input bit pOdd,
                         input bit mp, input logic [1:0] cs, input int div);
    @(negedge clk);
    modeIn      = {mp, pOdd, pEn, twoStop, cs};
    rateDivisor = 8'(div);
    modeWr      = 1'b1;
    @(negedge clk);
    modeWr  = 1'b0;
    curMp   = mp;
    bitClks = 16 * (div + 1) * (1 << (2 * cs));
  endtask

  // Driver: queue the expectations, then hand the byte over.
  task automatic sendTx(input logic [7:0] d, input bit mp, input bit hasX,
                        input bit x, input int stops, input string req);
    tx_item_t t;
    rx_item_t r;
    t.d = d; t.hasX = hasX; t.x = x; t.stops = stops; t.req = req;
    txExp.push_back(t);
    if (loopSel) begin
      r.v = {d, (curMp ? x : 1'b0), 1'b0, 1'b0};
      r.req = req;
      rxExp.push_back(r);
    end
    txData  = d;
    txMpBit = mp;
    txValid = 1'b1;
    forever begin
      if (txReady) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    txValid = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d, input bit mp, input bit fe,
                        input bit pe, input string req);
    rx_item_t r;
    r.v = {d, mp, fe, pe};
    r.req = req;
    rxExp.push_back(r);
  endtask

  task automatic driveFrame(input logic [7:0] d, input bit hasX, input bit x,
                            input bit stopGood);
    benchLine = 1'b0;
    repeat (bitClks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      benchLine = d[i];
      repeat (bitClks) @(negedge clk);
    end
    if (hasX) begin
      benchLine = x;
      repeat (bitClks) @(negedge clk);
    end
    if (stopGood) begin
      benchLine = 1'b1;
      repeat (bitClks) @(negedge clk);
    end else begin
      benchLine = 1'b0;
      repeat (bitClks * 3 / 4) @(negedge clk);
      benchLine = 1'b1;
      repeat (bitClks / 4) @(negedge clk);
    end
  endtask

  task automatic waitQuiet();
    int n = 0;
    while ((txExp.size() != 0 || rxExp.size() != 0 || txBusy) && n < 60000) begin
      @(negedge clk);
      n++;
    end
    repeat (2 * bitClks) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Transmit monitor: decodes frames on txLine at mid-bit.
  task automatic decodeTx();
    tx_item_t   t;
    logic [7:0] d;
    logic       sb, xb, s1;
    int         gap, seen;
    txBusy = 1'b1;
    if (txExp.size() == 0) begin
      t.d = '0; t.hasX = 1'b0; t.x = 1'b0; t.stops = 0; t.req = "R4";
      check(1'b0, "R4", "unexpected frame", 1, 0);
    end else begin
      t = txExp.pop_front();
    end
    repeat (bitClks / 2 - 1) @(negedge clk);
    sb = txLine;
    for (int i = 0; i < 8; i++) begin
      repeat (bitClks) @(negedge clk);
      d[i] = txLine;
    end
    xb = 1'b0;
    if (t.hasX) begin
      repeat (bitClks) @(negedge clk);
      xb = txLine;
    end
    repeat (bitClks) @(negedge clk);
    s1 = txLine;
    check({sb, xb, s1, d} == {1'b0, (t.hasX ? t.x : 1'b0), 1'b1, t.d}, t.req,
          "tx frame {start,extra,stop1,data}", {sb, xb, s1, d},
          {1'b0, (t.hasX ? t.x : 1'b0), 1'b1, t.d});
    if (t.stops > 0) begin
      gap = 0;
      while (txLine && gap < 3 * bitClks) begin
        @(negedge clk);
        gap++;
      end
      seen = (gap + 3 * bitClks / 4) / bitClks;
      check(seen == t.stops, "R5", "stop bits before next start", seen, t.stops);
    end
    txBusy = 1'b0;
  endtask

  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (txLine == 1'b0) decodeTx();
    end
  end

  // Receive monitor: scoreboard compare on every character strobe.
  initial begin
    rx_item_t r;
    forever begin
      @(negedge clk);
      if (rstN && rxValid) begin
        rxCount++;
        if (rxExp.size() == 0) begin
          check(1'b0, "R8", "unexpected character", {rxData, rxMpBit, rxFrameErr, rxParityErr}, 0);
        end else begin
          r = rxExp.pop_front();
          check({rxData, rxMpBit, rxFrameErr, rxParityErr} == r.v, r.req,
                "rx {data,mp,fe,pe}", {rxData, rxMpBit, rxFrameErr, rxParityErr}, r.v);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(txLine == 1'b1, "R1", "txLine after reset", txLine, 1);
    check(txReady == 1'b1, "R1", "txReady after reset", txReady, 1);
    check(rxValid == 1'b0, "R1", "rxValid after reset", rxValid, 0);

    // R2: reset mode gives one stop, no extra bit, 16-clock bits
    sendTx(8'hA5, 1'b0, 1'b0, 1'b0, 1, "R2");
    sendTx(8'h3C, 1'b0, 1'b0, 1'b0, 0, "R2");
    waitQuiet();

    // R3 R5 R6: two stops, even parity, divide-by-4 and divisor 2
    setMode(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 2);
    sendTx(8'h96, 1'b0, 1'b1, par(8'h96, 1'b0), 2, "R6");
    sendTx(8'h07, 1'b0, 1'b1, par(8'h07, 1'b0), 0, "R6");
    waitQuiet();

    // R3 R6: odd parity, divide-by-16
    setMode(1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 0);
    sendTx(8'h00, 1'b0, 1'b1, par(8'h00, 1'b1), 0, "R3");
    waitQuiet();

    // R3: divide-by-64
    setMode(1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 0);
    sendTx(8'h5A, 1'b0, 1'b0, 1'b0, 0, "R3");
    waitQuiet();

    // R7: marker format overrides odd parity on both sides
    setMode(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1);
    sendTx(8'h81, 1'b1, 1'b1, 1'b1, 1, "R7");
    sendTx(8'h81, 1'b0, 1'b1, 1'b0, 0, "R7");
    waitQuiet();

    // Receiver driven directly from the bench
    loopSel = 1'b0;
    setMode(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1);
    // R10: wrong even parity bit
    pushRx(8'h33, 1'b0, 1'b0, 1'b1, "R10");
    driveFrame(8'h33, 1'b1, 1'b1, 1'b1);
    repeat (2 * bitClks) @(negedge clk);

    // R9: second stop low is taken as the next start bit
    setMode(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1);
    pushRx(8'h12, 1'b0, 1'b0, 1'b0, "R9");
    pushRx(8'h34, 1'b0, 1'b0, 1'b0, "R9");
    driveFrame(8'h12, 1'b0, 1'b0, 1'b1);
    driveFrame(8'h34, 1'b0, 1'b0, 1'b1);
    repeat (2 * bitClks) @(negedge clk);

    // R9: low first stop is flagged, short low does not start a frame
    c0 = rxCount;
    pushRx(8'h55, 1'b0, 1'b1, 1'b0, "R9");
    driveFrame(8'h55, 1'b0, 1'b0, 1'b0);
    repeat (3 * bitClks) @(negedge clk);
    check(rxCount == c0 + 1, "R9", "characters after framing error", rxCount - c0, 1);

    // R8: start glitch shorter than half a bit is dropped
    c0 = rxCount;
    benchLine = 1'b0;
    repeat (bitClks / 4) @(negedge clk);
    benchLine = 1'b1;
    repeat (3 * bitClks) @(negedge clk);
    check(rxCount == c0, "R8", "characters after glitch", rxCount - c0, 0);
    pushRx(8'h6E, 1'b0, 1'b0, 1'b0, "R8");
    driveFrame(8'h6E, 1'b0, 1'b0, 1'b1);
    repeat (3 * bitClks) @(negedge clk);

    // R11: data held after the pulse
    check(rxValid == 1'b0, "R11", "rxValid after pulse", rxValid, 0);
    check(rxData == 8'h6E, "R11", "rxData held", rxData, 8'h6E);

    // R7: received marker bit, parity ignored even with wrong parity
    setMode(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1);
    pushRx(8'hF0, 1'b1, 1'b0, 1'b0, "R7");
    driveFrame(8'hF0, 1'b1, 1'b1, 1'b1);
    pushRx(8'h01, 1'b0, 1'b0, 1'b0, "R7");
    driveFrame(8'h01, 1'b1, 1'b0, 1'b1);
    waitQuiet();
    check(rxExp.size() == 0, "R7", "pending characters", rxExp.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule